// File: doc/BRIEF.md
# Serial Flash Write-Enable and Protection Controller

This block is the command-acceptance state machine of a serial flash. A front end deserialises each command and presents it for one clock when select rises: the opcode, the 24-bit address, and a flag that says whether select rose on a whole-byte boundary. The controller decides whether that command is taken, keeps the write-enable latch and the power-down state, and launches erase, program and page-write jobs towards the array. It also runs a busy timer whose length is a separate parameter for each job type.

Two level inputs act at any time. The write-protect pin guards the lowest 64 KB, which is the first 256 pages. The reset pin clears the latch and power-down, but only while no job runs. The status byte carries busy in bit 0 and the write-enable latch in bit 1, and the array job code comes out beside the start pulse.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After system reset the status byte is 00h, power-down is off, and neither cmd_accept nor array_start is high.
- R2: Opcode 06h sets status bit 1 and opcode 04h clears it. Each raises cmd_accept for one cycle, in the cycle after the command.
- R3: An array command is accepted when status bit 1 is 1, cmd_clean is 1, no job runs and the target is not protected. Array opcodes are DBh (page erase, code 0), D8h (sector erase, code 1), C7h (chip erase, code 2), 02h (program, code 3) and 0Ah (page write, code 4). In the next cycle array_start pulses, array_op carries the code, and status bit 0 becomes 1.
- R4: An array command that arrives while status bit 1 is 0 is not accepted and starts nothing.
- R5: An array command with cmd_clean at 0 is not accepted, and status bit 1 keeps its value.
- R6: While wp_n is 0, chip erase is refused, and so is every other array command whose address bits 18 to 16 are all zero. Address bits 23 to 19 play no part. A refused command leaves status bit 1 unchanged. Addresses with any of bits 18 to 16 set are still accepted.
- R7: Status bit 0 stays 1 for exactly the configured number of cycles for the job type. Bits 0 and 1 then clear on the same clock edge.
- R8: While a job runs, only opcode 05h (status read) is accepted. Every other opcode, 06h and 9Fh among them, has no effect.
- R9: Opcode B9h sets pwr_down. In power-down only ABh is accepted, and it clears pwr_down. Every other opcode has no effect.
- R10: When hw_rst_n is low and no job runs, status bit 1 and pwr_down clear and any command in that cycle is ignored. While a job runs, hw_rst_n has no effect.
- R11: Status bits 7 to 2 always read 0.
- R12: When idle and awake, read opcodes 03h, 0Bh and 9Fh and the opcode ABh are accepted and leave status bit 1 unchanged. Any opcode not named in these requirements is never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system (power-on) reset |
| cmd_valid | input | 1 | One-cycle strobe: a decoded command is complete |
| cmd_op | input | 8 | Opcode of the command |
| cmd_addr | input | 24 | Address bytes of the command |
| cmd_clean | input | 1 | Select rose on a whole-byte boundary |
| wp_n | input | 1 | Write-protect pin, low protects the lowest 64 KB |
| hw_rst_n | input | 1 | Hardware reset pin, active low |
| cmd_accept | output | 1 | Command accepted (one cycle, cycle after strobe) |
| array_start | output | 1 | Launch pulse to the array |
| array_op | output | 3 | Job code, valid with array_start |
| status | output | 8 | Status byte: bit 0 busy, bit 1 write-enable latch |
| pwr_down | output | 1 | Power-down state |

## Verification
Two events can land on the same clock edge: the busy timer running out, and a command or reset-pin level that would otherwise act on the latch. The bench issues 06h on exactly the last busy cycle of a chip erase, and holds hw_rst_n low across that cycle. It then judges that the command is refused, that bit 1 falls only because the job finished, and that the reset pin begins to act only on the next edge. A behavioural model advances on every clock and compares all outputs. It sees both cases, along with reset pulses in the middle of a job.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

    typedef enum logic [2:0] {
        AOP_PAGE_ERASE = 3'd0,
        AOP_SECT_ERASE = 3'd1,
        AOP_CHIP_ERASE = 3'd2,
        AOP_PROGRAM    = 3'd3,
        AOP_PAGE_WRITE = 3'd4
    } arr_op_e;

    typedef enum logic [3:0] {
        CLS_NONE,
        CLS_LATCH_SET,
        CLS_LATCH_CLR,
        CLS_SLEEP,
        CLS_WAKE,
        CLS_READ,
        CLS_STATUS,
        CLS_ARRAY
    } cmd_cls_e;

    localparam logic [7:0] OPC_LATCH_SET = 8'h06;
    localparam logic [7:0] OPC_LATCH_CLR = 8'h04;
    localparam logic [7:0] OPC_SLEEP     = 8'hB9;
    localparam logic [7:0] OPC_WAKE      = 8'hAB;
    localparam logic [7:0] OPC_STATUS    = 8'h05;
    localparam logic [7:0] OPC_READ      = 8'h03;
    localparam logic [7:0] OPC_READ_FAST = 8'h0B;
    localparam logic [7:0] OPC_IDENT     = 8'h9F;
    localparam logic [7:0] OPC_PG_ERASE  = 8'hDB;
    localparam logic [7:0] OPC_SC_ERASE  = 8'hD8;
    localparam logic [7:0] OPC_CH_ERASE  = 8'hC7;
    localparam logic [7:0] OPC_PROGRAM   = 8'h02;
    localparam logic [7:0] OPC_PG_WRITE  = 8'h0A;

    typedef struct packed {
        logic    wel;
        logic    pd;
        logic    accept;
        logic    start;
        arr_op_e op;
    } ctrl_t;

endpackage

// File: rtl/flash_cmd_filter.sv
module flash_cmd_filter
    import flash_wp_pkg::*;
#(
    parameter int ARRAY_AW = 19,
    parameter int PROT_LSB = 16
) (
    input  logic [7:0]                   op,
    input  logic [ARRAY_AW-PROT_LSB-1:0] region,
    input  logic                         wp_n,
    output cmd_cls_e                     cls,
    output arr_op_e                      aop,
    output logic                         blocked
);
    logic region_low;

    assign region_low = (region == '0);

    always_comb begin
        cls = CLS_NONE;
        aop = AOP_PAGE_ERASE;
        unique case (op)
            OPC_LATCH_SET: cls = CLS_LATCH_SET;
            OPC_LATCH_CLR: cls = CLS_LATCH_CLR;
            OPC_SLEEP:     cls = CLS_SLEEP;
            OPC_WAKE:      cls = CLS_WAKE;
            OPC_STATUS:    cls = CLS_STATUS;
            OPC_READ, OPC_READ_FAST, OPC_IDENT: cls = CLS_READ;
            OPC_PG_ERASE: begin cls = CLS_ARRAY; aop = AOP_PAGE_ERASE; end
            OPC_SC_ERASE: begin cls = CLS_ARRAY; aop = AOP_SECT_ERASE; end
            OPC_CH_ERASE: begin cls = CLS_ARRAY; aop = AOP_CHIP_ERASE; end
            OPC_PROGRAM:  begin cls = CLS_ARRAY; aop = AOP_PROGRAM;    end
            OPC_PG_WRITE: begin cls = CLS_ARRAY; aop = AOP_PAGE_WRITE; end
            default:      cls = CLS_NONE;
        endcase
    end

    // Chip erase always touches the guarded region; the others only when aimed at it.
    assign blocked = !wp_n && (cls == CLS_ARRAY) &&
                     ((aop == AOP_CHIP_ERASE) || region_low);

endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer
    import flash_wp_pkg::*;
#(
    parameter int T_PAGE_ERASE = 20,
    parameter int T_SECT_ERASE = 30,
    parameter int T_CHIP_ERASE = 40,
    parameter int T_PROGRAM    = 12,
    parameter int T_PAGE_WRITE = 16
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load,
    input  arr_op_e op,
    output logic    busy,
    output logic    done
);
    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int T_MAX = max_of(max_of(max_of(T_PAGE_ERASE, T_SECT_ERASE),
                                         max_of(T_CHIP_ERASE, T_PROGRAM)), T_PAGE_WRITE);
    localparam int CNT_W = $clog2(T_MAX + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    function automatic logic [CNT_W-1:0] job_len(input arr_op_e o);
        case (o)
            AOP_PAGE_ERASE: return CNT_W'(T_PAGE_ERASE);
            AOP_SECT_ERASE: return CNT_W'(T_SECT_ERASE);
            AOP_CHIP_ERASE: return CNT_W'(T_CHIP_ERASE);
            AOP_PROGRAM:    return CNT_W'(T_PROGRAM);
            default:        return CNT_W'(T_PAGE_WRITE);
        endcase
    endfunction

    assign done = tmr_q.busy && (tmr_q.cnt == CNT_W'(1));
    assign busy = tmr_q.busy;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = job_len(op);
        end else if (done) begin
            tmr_d.busy = 1'b0;
            tmr_d.cnt  = '0;
        end else if (tmr_q.busy) begin
            tmr_d.cnt  = tmr_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R7: a launched job shows busy on the following cycle
    p_load_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> tmr_q.busy);
    // R7: busy cannot drop before the count runs out
    p_hold_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.busy && !done) |=> tmr_q.busy);
    // R8: no second launch while a job runs
    p_no_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.busy |-> !load);

endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
    import flash_wp_pkg::*;
#(
    parameter int ADDR_W       = 24,
    parameter int ARRAY_AW     = 19,
    parameter int PAGE_BITS    = 8,
    parameter int PROT_PG_LOG2 = 8,
    parameter int T_PAGE_ERASE = 20,
    parameter int T_SECT_ERASE = 30,
    parameter int T_CHIP_ERASE = 40,
    parameter int T_PROGRAM    = 12,
    parameter int T_PAGE_WRITE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_clean,
    input  logic              wp_n,
    input  logic              hw_rst_n,
    output logic              cmd_accept,
    output logic              array_start,
    output logic [2:0]        array_op,
    output logic [7:0]        status,
    output logic              pwr_down
);
    localparam int PROT_LSB = PAGE_BITS + PROT_PG_LOG2;

    ctrl_t    st_d, st_q;
    cmd_cls_e cls;
    arr_op_e  aop;
    logic     blocked;
    logic     busy, done, launch;
    logic     unused_addr;

    assign unused_addr = ^{cmd_addr[ADDR_W-1:ARRAY_AW], cmd_addr[PROT_LSB-1:0]};

    flash_cmd_filter #(
        .ARRAY_AW (ARRAY_AW),
        .PROT_LSB (PROT_LSB)
    ) u_filter (
        .op      (cmd_op),
        .region  (cmd_addr[ARRAY_AW-1:PROT_LSB]),
        .wp_n    (wp_n),
        .cls     (cls),
        .aop     (aop),
        .blocked (blocked)
    );

    flash_busy_timer #(
        .T_PAGE_ERASE (T_PAGE_ERASE),
        .T_SECT_ERASE (T_SECT_ERASE),
        .T_CHIP_ERASE (T_CHIP_ERASE),
        .T_PROGRAM    (T_PROGRAM),
        .T_PAGE_WRITE (T_PAGE_WRITE)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (launch),
        .op    (aop),
        .busy  (busy),
        .done  (done)
    );

    always_comb begin
        st_d        = st_q;
        st_d.accept = 1'b0;
        st_d.start  = 1'b0;
        launch      = 1'b0;
        if (done) st_d.wel = 1'b0;
        if (!hw_rst_n && !busy) begin
            st_d.wel = 1'b0;
            st_d.pd  = 1'b0;
        end else if (cmd_valid) begin
            if (st_q.pd) begin
                if (cls == CLS_WAKE) begin
                    st_d.accept = 1'b1;
                    st_d.pd     = 1'b0;
                end
            end else if (busy) begin
                st_d.accept = (cls == CLS_STATUS);
            end else begin
                unique case (cls)
                    CLS_LATCH_SET: begin st_d.accept = 1'b1; st_d.wel = 1'b1; end
                    CLS_LATCH_CLR: begin st_d.accept = 1'b1; st_d.wel = 1'b0; end
                    CLS_SLEEP:     begin st_d.accept = 1'b1; st_d.pd  = 1'b1; end
                    CLS_WAKE, CLS_READ, CLS_STATUS: st_d.accept = 1'b1;
                    CLS_ARRAY: begin
                        if (st_q.wel && cmd_clean && !blocked) begin
                            st_d.accept = 1'b1;
                            st_d.start  = 1'b1;
                            st_d.op     = aop;
                            launch      = 1'b1;
                        end
                    end
                    default: st_d.accept = 1'b0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_accept  = st_q.accept;
    assign array_start = st_q.start;
    assign array_op    = st_q.op;
    assign pwr_down    = st_q.pd;
    assign status      = {6'b0, st_q.wel, busy};

    // R2: latch-set opcode from idle, awake, out of pin reset sets bit 1
    p_latch_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && hw_rst_n && !pwr_down && !status[0] && cmd_op == 8'h06)
        |=> (status[1] && cmd_accept));
    // R3: a launch only follows a set latch
    p_start_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        array_start |-> $past(status[1]));
    // R6: chip erase never launches under write protect
    p_chip_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !wp_n && cmd_op == 8'hC7) |=> !array_start);
    // R7: bit 1 is down whenever busy falls
    p_done_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> !status[1]);
    // R9: power-down lets only the wake opcode through
    p_pd_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down && hw_rst_n && cmd_valid && cmd_op != 8'hAB) |=> (!cmd_accept && pwr_down));
    // R10: reset pin while idle clears latch and power-down
    p_pin_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_rst_n && !status[0]) |=> (!status[1] && !pwr_down && !cmd_accept));

endmodule

// File: tb/flash_wp_ctrl_bench.sv
module flash_wp_ctrl_bench;
    localparam int D_PE = 20, D_SE = 30, D_CE = 40, D_PP = 12, D_PW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_op = 8'h00;
    logic [23:0] cmd_addr = 24'h0;
    logic        cmd_clean = 1'b1;
    logic        wp_n = 1'b1;
    logic        hw_rst_n = 1'b1;
    logic        cmd_accept, array_start, pwr_down;
    logic [2:0]  array_op;
    logic [7:0]  status;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    flash_wp_ctrl #(
        .T_PAGE_ERASE (D_PE), .T_SECT_ERASE (D_SE), .T_CHIP_ERASE (D_CE),
        .T_PROGRAM (D_PP), .T_PAGE_WRITE (D_PW)
    ) u_flash_wp_ctrl (
        .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
        .cmd_addr (cmd_addr), .cmd_clean (cmd_clean), .wp_n (wp_n),
        .hw_rst_n (hw_rst_n), .cmd_accept (cmd_accept), .array_start (array_start),
        .array_op (array_op), .status (status), .pwr_down (pwr_down)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_wel = 0, m_pd = 0, m_busy = 0, m_left = 0, m_acc = 0, m_start = 0, m_op = 0;

    function automatic int job_code(input logic [7:0] op);
        case (op)
            8'hDB: return 0; 8'hD8: return 1; 8'hC7: return 2;
            8'h02: return 3; 8'h0A: return 4; default: return -1;
        endcase
    endfunction

    function automatic int job_len(input int code);
        case (code)
            0: return D_PE; 1: return D_SE; 2: return D_CE; 3: return D_PP; default: return D_PW;
        endcase
    endfunction

    always @(posedge clk) begin
        int n_wel, n_pd, n_busy, n_left, code;
        bit guarded;
        if (!rst_n) begin
            m_wel = 0; m_pd = 0; m_busy = 0; m_left = 0; m_acc = 0; m_start = 0;
        end else begin
            n_wel = m_wel; n_pd = m_pd; n_busy = m_busy; n_left = m_left;
            m_acc = 0; m_start = 0;
            if (m_busy != 0) begin
                n_left = m_left - 1;
                if (n_left == 0) begin n_busy = 0; n_wel = 0; end
            end
            code = job_code(cmd_op);
            guarded = !wp_n && (code == 2 || cmd_addr[18:16] == 3'b000);
            if (!hw_rst_n && m_busy == 0) begin
                n_wel = 0; n_pd = 0;
            end else if (cmd_valid) begin
                if (m_pd != 0) begin
                    if (cmd_op == 8'hAB) begin m_acc = 1; n_pd = 0; end
                end else if (m_busy != 0) begin
                    if (cmd_op == 8'h05) m_acc = 1;
                end else if (cmd_op == 8'h06) begin m_acc = 1; n_wel = 1;
                end else if (cmd_op == 8'h04) begin m_acc = 1; n_wel = 0;
                end else if (cmd_op == 8'hB9) begin m_acc = 1; n_pd = 1;
                end else if (cmd_op inside {8'hAB, 8'h03, 8'h0B, 8'h05, 8'h9F}) begin m_acc = 1;
                end else if (code >= 0 && m_wel != 0 && cmd_clean && !guarded) begin
                    m_acc = 1; m_start = 1; m_op = code;
                    n_busy = 1; n_left = job_len(code);
                end
            end
            m_wel = n_wel; m_pd = n_pd; m_busy = n_busy; m_left = n_left;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R11 status byte", status, (m_wel << 1) | m_busy);
            chk("R2 cmd_accept", cmd_accept, m_acc);
            chk("R3 array_start", array_start, m_start);
            if (m_start != 0) chk("R3 array_op", array_op, m_op);
            chk("R9 pwr_down", pwr_down, m_pd);
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(input logic [7:0] op, input logic [23:0] addr, input logic clean);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_clean = clean;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_clean = 1'b1;
    endtask

    task automatic job_and_time(input logic [7:0] op, input logic [23:0] addr,
                                input int code, input int len);
        int n;
        send(op, addr, 1'b1);
        chk("R3 start pulse", array_start, 1);
        chk("R3 job code", array_op, code);
        chk("R3 busy raised", status, 8'h03);
        n = 1;
        forever begin
            @(negedge clk);
            if (status[0]) n++; else break;
        end
        chk("R7 busy length", n, len);
        chk("R7 bits clear together", status, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 status after reset", status, 8'h00);
        chk("R1 pwr_down after reset", pwr_down, 0);
        chk("R1 outputs idle", {cmd_accept, array_start}, 0);
        rst_n = 1'b1;

        send(8'h06, 24'h0, 1'b1);
        chk("R2 latch set", status, 8'h02);
        chk("R2 accept", cmd_accept, 1);
        send(8'h04, 24'h0, 1'b1);
        chk("R2 latch clear", status, 8'h00);

        send(8'h02, 24'h030000, 1'b1);
        chk("R4 no start without latch", array_start, 0);
        chk("R4 not accepted", cmd_accept, 0);

        send(8'h06, 24'h0, 1'b1);
        send(8'h0A, 24'h030000, 1'b0);
        chk("R5 ragged command refused", array_start, 0);
        chk("R5 latch kept", status, 8'h02);

        wp_n = 1'b0;
        send(8'hD8, 24'h000000, 1'b1);
        chk("R6 sector 0 refused", array_start, 0);
        send(8'hC7, 24'h070000, 1'b1);
        chk("R6 chip erase refused", array_start, 0);
        send(8'hDB, 24'h080100, 1'b1);
        chk("R6 upper bits ignored", array_start, 0);
        chk("R6 latch kept", status, 8'h02);
        job_and_time(8'h02, 24'h010000, 3, D_PP);
        wp_n = 1'b1;

        send(8'h06, 24'h0, 1'b1);
        job_and_time(8'hDB, 24'h000200, 0, D_PE);
        send(8'h06, 24'h0, 1'b1);
        job_and_time(8'h0A, 24'h000010, 4, D_PW);
        send(8'h06, 24'h0, 1'b1);
        wp_n = 1'b0;
        job_and_time(8'hD8, 24'h050000, 1, D_SE);
        wp_n = 1'b1;

        // job running: only status read, reset pin ignored
        send(8'h06, 24'h0, 1'b1);
        send(8'h02, 24'h040000, 1'b1);
        send(8'h06, 24'h0, 1'b1);
        chk("R8 latch-set refused while busy", cmd_accept, 0);
        send(8'h05, 24'h0, 1'b1);
        chk("R8 status read accepted", cmd_accept, 1);
        send(8'h9F, 24'h0, 1'b1);
        chk("R8 ident refused while busy", cmd_accept, 0);
        @(negedge clk); hw_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 pin reset ignored while busy", status, 8'h03);
        hw_rst_n = 1'b1;
        while (status[0]) @(negedge clk);
        chk("R7 job ends", status, 8'h00);

        // corner: command and reset pin meet the final busy cycle
        send(8'h06, 24'h0, 1'b1);
        send(8'hC7, 24'h0, 1'b1);
        chk("R3 chip erase launched", array_op, 2);
        repeat (D_CE - 2) @(negedge clk);
        hw_rst_n = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 8'h06;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R8 final-cycle command refused", cmd_accept, 0);
        chk("R7 job ended on time", status, 8'h00);
        hw_rst_n = 1'b1;

        send(8'hB9, 24'h0, 1'b1);
        chk("R9 power-down entered", pwr_down, 1);
        send(8'h06, 24'h0, 1'b1);
        chk("R9 latch-set ignored", status, 8'h00);
        send(8'h03, 24'h0, 1'b1);
        chk("R9 read ignored", cmd_accept, 0);
        send(8'hAB, 24'h0, 1'b1);
        chk("R9 wake accepted", cmd_accept, 1);
        chk("R9 power-down left", pwr_down, 0);

        send(8'hB9, 24'h0, 1'b1);
        send(8'h06, 24'h0, 1'b0);
        @(negedge clk); hw_rst_n = 1'b0;
        @(negedge clk); hw_rst_n = 1'b1;
        chk("R10 pin reset leaves power-down", pwr_down, 0);
        send(8'h06, 24'h0, 1'b1);
        @(negedge clk); hw_rst_n = 1'b0;
        cmd_valid = 1'b1; cmd_op = 8'h04;
        @(negedge clk); hw_rst_n = 1'b1; cmd_valid = 1'b0;
        chk("R10 latch cleared by pin", status, 8'h00);
        chk("R10 command ignored during pin reset", cmd_accept, 0);

        send(8'h06, 24'h0, 1'b1);
        send(8'h03, 24'h0, 1'b1);
        chk("R12 read accepted", cmd_accept, 1);
        send(8'h0B, 24'h0, 1'b1);
        chk("R12 fast read accepted", cmd_accept, 1);
        send(8'h9F, 24'h0, 1'b1);
        chk("R12 ident accepted", cmd_accept, 1);
        send(8'hAB, 24'h0, 1'b1);
        chk("R12 wake while awake accepted", cmd_accept, 1);
        chk("R12 latch untouched by reads", status, 8'h02);
        send(8'h55, 24'h0, 1'b1);
        chk("R12 unknown opcode refused", cmd_accept, 0);
        chk("R11 reserved bits zero", status[7:2], 0);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule